// File: doc/BRIEF.md
# Two-Level Lookahead Adder/Subtractor

This block is a purely combinational 32-bit two's-complement adder/subtractor. The word is cut into four 8-bit slices. Each slice forms per-bit generate and propagate terms and derives every one of its internal carries as a flat sum of products of those terms and the slice carry-in. No slice carry is built from the carry of the bit below it. Each slice also reports a slice generate and a slice propagate term.

A second-level lookahead unit takes the four slice terms and the word carry-in. From these it produces the carries into slices 1, 2 and 3 and the final carry-out, all in flat form. Carries never ripple from one slice to the next.

A single mode bit chooses the operation. When it is set, the second operand is inverted bit by bit and the word carry-in is forced to 1, which gives A + ~B + 1. The block reports the 32-bit result, the carry out of bit 31, and a signed overflow flag taken as the XOR of the carries into and out of bit 31.

Top module: `lookahead_addsub`

## Requirements
- R1: With `sub_en` = 0, {`carry_out`, `result`} equals the 33-bit unsigned sum `op_a` + `op_b`.
- R2: With `sub_en` = 1, `result` equals (`op_a` − `op_b`) modulo 2^32, and `carry_out` is 1 exactly when `op_a` ≥ `op_b` as unsigned numbers.
- R3: With `sub_en` = 0, `overflow` is 1 exactly when the signed sum of `op_a` and `op_b` lies outside −2^31 .. 2^31−1.
- R4: With `sub_en` = 1, `overflow` is 1 exactly when the signed difference `op_a` − `op_b` lies outside −2^31 .. 2^31−1.
- R5: A carry made in the low bit of a slice and propagated through all its other bits reaches the next slice. For example, 0x000000FF + 1 gives 0x00000100.
- R6: The carry into each slice from the lookahead unit equals G_k + P_k·c_k of the slice below, where G and P are the slice generate and propagate terms. A carry travels across every slice: 0xFFFFFFFF + 1 gives result 0 with carry_out 1.
- R7: Subtracting an operand from itself gives result 0, carry_out 1 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (minuend in subtract mode) |
| op_b | input | 32 | Second operand (subtrahend in subtract mode) |
| sub_en | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | 32 | Sum or difference, modulo 2^32 |
| carry_out | output | 1 | Carry out of bit 31 |
| overflow | output | 1 | Signed overflow of the operation |

## Verification
The assertions are immediate checks on combinational values. They assume that every input is a known 0 or 1 whenever they evaluate, and that the logic has settled before a result is compared. The bench meets both conditions. It drives every input to a defined value on one clock edge and reads the outputs half a period later. Operands come from a fixed list of corner words and from random 32-bit values, applied in both modes, so no X or Z ever reaches the block.

// File: rtl/lookahead_pkg.sv
package lookahead_pkg;
  localparam int GRP_W  = 8;
  localparam int NGRP   = 4;
  localparam int WORD_W = GRP_W * NGRP;
  localparam int LA_W   = (GRP_W > NGRP) ? GRP_W : NGRP;

  typedef logic [LA_W-1:0] la_vec_t;

  // Flat sum of products: carry into position j of a chain with
  // generate vector g, propagate vector p and chain input cin.
  function automatic logic flat_carry(la_vec_t g, la_vec_t p, logic cin, int j);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int k = 0; k < LA_W; k++) begin
      if (k < j) begin
        term = g[k];
        for (int m = 0; m < LA_W; m++)
          if (m > k && m < j) term = term & p[m];
        acc = acc | term;
      end
    end
    term = cin;
    for (int m = 0; m < LA_W; m++)
      if (m < j) term = term & p[m];
    return acc | term;
  endfunction

  // Chain generate over the first n positions (no carry-in term).
  function automatic logic chain_gen(la_vec_t g, la_vec_t p, int n);
    return flat_carry(g, p, 1'b0, n);
  endfunction
endpackage

// File: rtl/cla_slice.sv
module cla_slice
  import lookahead_pkg::*;
#(
  parameter int W = GRP_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic [W-1:0] carry_in_bit,
  output logic         slice_g,
  output logic         slice_p
);
  logic [W-1:0] g;
  logic [W-1:0] p;
  la_vec_t      g_ext;
  la_vec_t      p_ext;

  assign g = a & b;
  assign p = a | b;

  always_comb begin
    g_ext = '0;
    p_ext = '0;
    g_ext[W-1:0] = g;
    p_ext[W-1:0] = p;
  end

  for (genvar j = 0; j < W; j++) begin : g_bit
    assign carry_in_bit[j] = flat_carry(g_ext, p_ext, cin, j);
    assign s[j] = a[j] ^ b[j] ^ carry_in_bit[j];
  end

  assign slice_g = chain_gen(g_ext, p_ext, W);
  assign slice_p = &p;
endmodule

// File: rtl/carry_lookahead_unit.sv
module carry_lookahead_unit
  import lookahead_pkg::*;
#(
  parameter int N = NGRP
) (
  input  logic [N-1:0] grp_g,
  input  logic [N-1:0] grp_p,
  input  logic         c0,
  output logic [N:0]   grp_carry
);
  la_vec_t g_ext;
  la_vec_t p_ext;

  always_comb begin
    g_ext = '0;
    p_ext = '0;
    g_ext[N-1:0] = grp_g;
    p_ext[N-1:0] = grp_p;
  end

  for (genvar k = 0; k <= N; k++) begin : g_carry
    assign grp_carry[k] = flat_carry(g_ext, p_ext, c0, k);
  end
endmodule

// File: rtl/lookahead_addsub.sv
module lookahead_addsub
  import lookahead_pkg::*;
(
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              sub_en,
  output logic [WORD_W-1:0] result,
  output logic              carry_out,
  output logic              overflow
);
  logic [WORD_W-1:0] b_eff;
  logic [WORD_W-1:0] bit_carry;
  logic [NGRP-1:0]   grp_g;
  logic [NGRP-1:0]   grp_p;
  logic [NGRP:0]     grp_carry;

  assign b_eff = op_b ^ {WORD_W{sub_en}};

  carry_lookahead_unit #(.N(NGRP)) u_la (
    .grp_g     (grp_g),
    .grp_p     (grp_p),
    .c0        (sub_en),
    .grp_carry (grp_carry)
  );

  for (genvar k = 0; k < NGRP; k++) begin : g_slice
    cla_slice #(.W(GRP_W)) u_slice (
      .a            (op_a[k*GRP_W +: GRP_W]),
      .b            (b_eff[k*GRP_W +: GRP_W]),
      .cin          (grp_carry[k]),
      .s            (result[k*GRP_W +: GRP_W]),
      .carry_in_bit (bit_carry[k*GRP_W +: GRP_W]),
      .slice_g      (grp_g[k]),
      .slice_p      (grp_p[k])
    );
  end

  assign carry_out = grp_carry[NGRP];
  assign overflow  = bit_carry[WORD_W-1] ^ grp_carry[NGRP];
endmodule

// File: rtl/lookahead_addsub_checker.sv
module lookahead_addsub_checker
  import lookahead_pkg::*;
(
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic              sub_en,
  input logic [WORD_W-1:0] result,
  input logic              carry_out,
  input logic              overflow,
  input logic [WORD_W-1:0] b_eff,
  input logic [NGRP-1:0]   grp_g,
  input logic [NGRP-1:0]   grp_p,
  input logic [NGRP:0]     grp_carry
);
  logic [WORD_W:0] wide;

  always_comb begin
    wide = {1'b0, op_a} + {1'b0, b_eff} + {{WORD_W{1'b0}}, sub_en};
    if (!$isunknown({op_a, op_b, sub_en})) begin
      AST_SUM_MATCH: assert ({carry_out, result} == wide)                   // R1
        else $error("sum mismatch");
      AST_SUB_BORROW: assert (!sub_en || carry_out == (op_a >= op_b))       // R2
        else $error("subtract carry mismatch");
      AST_ADD_OVERFLOW: assert (sub_en || overflow ==
        ((op_a[WORD_W-1] == op_b[WORD_W-1]) && (result[WORD_W-1] != op_a[WORD_W-1]))) // R3
        else $error("add overflow mismatch");
      AST_SUB_OVERFLOW: assert (!sub_en || overflow ==
        ((op_a[WORD_W-1] != op_b[WORD_W-1]) && (result[WORD_W-1] != op_a[WORD_W-1]))) // R4
        else $error("sub overflow mismatch");
      AST_SELF_SUB: assert (!(sub_en && op_a == op_b) ||
        (result == '0 && carry_out && !overflow))                          // R7
        else $error("self subtract mismatch");
      for (int k = 0; k < NGRP; k++) begin
        AST_GROUP_CARRY: assert (grp_carry[k+1] ==
          (grp_g[k] | (grp_p[k] & grp_carry[k])))                           // R6
          else $error("slice carry %0d mismatch", k);
      end
    end
  end
endmodule

bind lookahead_addsub lookahead_addsub_checker u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .sub_en    (sub_en),
  .result    (result),
  .carry_out (carry_out),
  .overflow  (overflow),
  .b_eff     (b_eff),
  .grp_g     (grp_g),
  .grp_p     (grp_p),
  .grp_carry (grp_carry)
);

// File: tb/lookahead_addsub_tb.sv
module lookahead_addsub_tb;
  logic        clk = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        sub_en = 1'b0;
  logic [31:0] result;
  logic        carry_out;
  logic        overflow;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  lookahead_addsub u_dut (
    .op_a      (op_a),
    .op_b      (op_b),
    .sub_en    (sub_en),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow)
  );

  task automatic check_bit(string tag, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [31:0] b, logic sub, string tag);
    longint signed   sa;
    longint signed   sb;
    longint signed   sres;
    longint unsigned ures;
    logic [31:0]     exp_s;
    logic            exp_c;
    logic            exp_v;
    @(posedge clk);
    op_a = a;
    op_b = b;
    sub_en = sub;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (!sub) begin
      ures  = longint'(a) + longint'(b);
      exp_s = ures[31:0];
      exp_c = ures[32];
      sres  = sa + sb;
    end else begin
      exp_s = a - b;
      exp_c = (a >= b);
      sres  = sa - sb;
    end
    exp_v = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
    @(negedge clk);
    n_checks++;
    if (result !== exp_s) begin
      n_fail++;
      $display("FAIL %s result: actual %h expected %h", tag, result, exp_s);
    end
    check_bit(tag, "carry_out", carry_out, exp_c);
    check_bit(tag, "overflow", overflow, exp_v);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] corners [5];
    corners[0] = 32'h0000_0000;
    corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h7FFF_FFFF;
    corners[3] = 32'h8000_0000;
    corners[4] = 32'h0000_0001;

    // Initial state: zero inputs give zero result, no carry, no overflow
    apply(32'h0, 32'h0, 1'b0, "R1 zero");
    // R5: carry chains through a full slice
    apply(32'h0000_00FF, 32'h1, 1'b0, "R5");
    apply(32'h0000_FF00, 32'h0000_0100, 1'b0, "R5");
    apply(32'h00FF_FFFF, 32'h1, 1'b0, "R5");
    apply(32'h0000_0100, 32'h1, 1'b1, "R5 borrow");
    // R6: carry across every slice
    apply(32'hFFFF_FFFF, 32'h1, 1'b0, "R6");
    apply(32'h0, 32'h1, 1'b1, "R6 borrow");
    // R3 / R4 overflow corners
    apply(32'h7FFF_FFFF, 32'h1, 1'b0, "R3");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R3");
    apply(32'h8000_0000, 32'h1, 1'b1, "R4");
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R4");
    // R7: self subtraction
    apply(32'h8000_0000, 32'h8000_0000, 1'b1, "R7");
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, "R7");
    // Corner cross product in both modes
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++) begin
        apply(corners[i], corners[j], 1'b0, "R1 corner");
        apply(corners[i], corners[j], 1'b1, "R2 corner");
      end
    // Random operands
    for (int n = 0; n < 400; n++) begin
      apply($urandom, $urandom, 1'b0, "R1 R3 random");
      apply($urandom, $urandom, 1'b1, "R2 R4 random");
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule